// File: doc/BRIEF.md
# Split-Strobe Multiplexed-Bus Byte Memory

This block is a byte-wide memory slave on a shared 8-bit address/data bus. An access begins with address capture: a rising edge on the low strobe copies the bus into an 8-bit low address register, and a rising edge on the high strobe copies the bus into a narrower high address register. Each half is a register of its own. The two halves may be loaded in either order. A half that does not change between accesses can stay loaded.

A chip enable qualifies the read and write controls. A write stores the byte on the bus into the addressed location once for each assertion. A read puts the addressed byte on the data output and raises an output-enable, which an outer pad ring turns into a tristate driver. Strobes and controls arrive asynchronously, so they pass through two-flop synchronisers into the system clock domain. Read and write must never be active together. If they are, the block stores nothing, keeps its output disabled and sets a sticky error flag.

The high address width is a parameter. The array holds 2^(8+HI_W) bytes and is addressed as {high, low}. A 13-bit (8K) part uses HI_W = 5. The default is 3, which keeps the default array small.

Top module: `muxbus_ram`

## Requirements
- R1: After reset, busOe and protoErr are 0 and both address registers are 0.
- R2: A rising edge on strobeLo loads busIn[7:0] into the low address register.
- R3: A rising edge on strobeHi loads busIn[HI_W-1:0] into the high address register. Bus lines HI_W to 7 are ignored.
- R4: The two halves can be loaded in either order, and both orders give the same location.
- R5: Each address half keeps its value until its own strobe rises again, so a later access can reuse it without reloading.
- R6: While chipEn is 1 and rdEn is 0, the leading edge of wrEn stores busIn into location {high, low} exactly once. Later changes on the bus while wrEn stays high do not change the stored byte.
- R7: While chipEn and rdEn are 1 and wrEn is 0, busOe is 1 and busOut carries the addressed byte.
- R8: While chipEn is 0, rdEn and wrEn have no effect: busOe stays 0 and nothing is stored. The address strobes still load.
- R9: If chipEn, rdEn and wrEn are all 1 at once, nothing is stored, busOe stays 0, and protoErr becomes 1 and stays 1 until reset.
- R10: Each input change takes effect within 3 clock edges, and busOe falls within 3 edges of rdEn or chipEn falling. The bus value must be held for 4 clocks after a strobe rises or after wrEn rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busIn | input | 8 | Bus value seen at the pins |
| busOut | output | 8 | Read data driven toward the bus |
| busOe | output | 1 | Bus drive enable for busOut |
| strobeLo | input | 1 | Low address strobe, active on its rising edge |
| strobeHi | input | 1 | High address strobe, active on its rising edge |
| chipEn | input | 1 | Chip enable, active high |
| rdEn | input | 1 | Read enable, active high |
| wrEn | input | 1 | Write enable, active high |
| protoErr | output | 1 | Sticky flag set when read and write are active together |

## Verification
The bench loads the halves in both orders and reuses a half across accesses. A design that cleared a half, or that needed both strobes for each access, would read from the wrong location. It also loads the high half with junk on the upper bus lines, which catches a design that takes too many bits.

The bench holds wrEn high while it changes the bus. A level-triggered store would overwrite the byte this way.

With chipEn low, the bench drives reads and writes and also moves a strobe. A design that gated the strobes with chipEn, or did not gate the controls with it, shows up at the read that follows.

The simultaneous read-and-write case must leave the memory unchanged, the output off and the flag set for good.

// File: rtl/muxram_pkg.sv
package muxram_pkg;
  // Strobes from control to datapath, one clock wide except drive
  typedef struct packed {
    logic loadLo;  // capture low address half
    logic loadHi;  // capture high address half
    logic store;   // commit bus byte to array
    logic drive;   // read is active, enable output
  } ctrl_t;
endpackage

// File: rtl/muxram_ctrl.sv
module muxram_ctrl
  import muxram_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  strobeLo,
  input  logic  strobeHi,
  input  logic  chipEn,
  input  logic  rdEn,
  input  logic  wrEn,
  output ctrl_t ctrl,
  output logic  protoErr
);
  localparam int NSIG = 5;

  logic [NSIG-1:0] rawIn;
  logic [NSIG-1:0] syncPipe [SYNC_STAGES];
  logic [NSIG-1:0] synced;
  logic loPrev, hiPrev, wrPrev;
  logic ceS, rdS, wrS, loS, hiS;
  logic rdQual, wrQual;

  assign rawIn = {wrEn, rdEn, chipEn, strobeHi, strobeLo};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncPipe[i] <= '0;
    end else begin
      syncPipe[0] <= rawIn;
      for (int i = 1; i < SYNC_STAGES; i++) syncPipe[i] <= syncPipe[i-1];
    end
  end

  assign synced = syncPipe[SYNC_STAGES-1];
  assign loS = synced[0];
  assign hiS = synced[1];
  assign ceS = synced[2];
  assign rdS = synced[3];
  assign wrS = synced[4];

  assign rdQual = ceS & rdS;
  assign wrQual = ceS & wrS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loPrev   <= 1'b0;
      hiPrev   <= 1'b0;
      wrPrev   <= 1'b0;
      protoErr <= 1'b0;
    end else begin
      loPrev   <= loS;
      hiPrev   <= hiS;
      wrPrev   <= wrQual;
      protoErr <= protoErr | (rdQual & wrQual);
    end
  end

  always_comb begin
    ctrl.loadLo = loS & ~loPrev;
    ctrl.loadHi = hiS & ~hiPrev;
    ctrl.store  = wrQual & ~wrPrev & ~rdQual;
    ctrl.drive  = rdQual & ~wrQual;
  end
endmodule

// File: rtl/muxram_dp.sv
module muxram_dp
  import muxram_pkg::*;
#(
  parameter int LO_W = 8,
  parameter int HI_W = 3,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [DW-1:0]   busIn,
  input  ctrl_t           ctrl,
  output logic [DW-1:0]   busOut,
  output logic [LO_W-1:0] addrLo,
  output logic [HI_W-1:0] addrHi
);
  localparam int AW    = LO_W + HI_W;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] memArr [DEPTH];
  logic [AW-1:0] addr;
  logic [DW-1:0] rdReg;

  assign addr = {addrHi, addrLo};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLo <= '0;
      addrHi <= '0;
    end else begin
      if (ctrl.loadLo) addrLo <= busIn[LO_W-1:0];
      if (ctrl.loadHi) addrHi <= busIn[HI_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.store) memArr[addr] <= busIn;
    rdReg <= memArr[addr];
  end

  assign busOut = rdReg;
endmodule

// File: rtl/muxbus_ram.sv
module muxbus_ram
  import muxram_pkg::*;
#(
  parameter int HI_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] busIn,
  output logic [7:0] busOut,
  output logic       busOe,
  input  logic       strobeLo,
  input  logic       strobeHi,
  input  logic       chipEn,
  input  logic       rdEn,
  input  logic       wrEn,
  output logic       protoErr
);
  localparam int LO_W = 8;
  localparam int DW   = 8;

  ctrl_t           ctrlBus;
  logic [LO_W-1:0] addrLo;
  logic [HI_W-1:0] addrHi;

  muxram_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .strobeLo(strobeLo), .strobeHi(strobeHi),
    .chipEn(chipEn), .rdEn(rdEn), .wrEn(wrEn), .ctrl(ctrlBus), .protoErr(protoErr)
  );

  muxram_dp #(.LO_W(LO_W), .HI_W(HI_W), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .busIn(busIn), .ctrl(ctrlBus),
    .busOut(busOut), .addrLo(addrLo), .addrHi(addrHi)
  );

  assign busOe = ctrlBus.drive;
endmodule

// File: rtl/muxbus_ram_chk.sv
module muxbus_ram_chk
  import muxram_pkg::*;
#(
  parameter int HI_W = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic            chipEn,
  input logic            busOe,
  input logic            protoErr,
  input ctrl_t           ctrlBus,
  input logic [7:0]      addrLo,
  input logic [HI_W-1:0] addrHi
);
  // R9
  oe_store_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> !ctrlBus.store);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);

  // R6
  single_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlBus.store |=> !ctrlBus.store);

  // R8
  ce_gates_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(chipEn) && !$past(chipEn, 2) && !$past(chipEn, 3)) |-> !busOe);

  // R5
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlBus.loadHi |=> $stable(addrHi));

  // R5
  lo_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlBus.loadLo |=> $stable(addrLo));
endmodule

bind muxbus_ram muxbus_ram_chk #(.HI_W(HI_W)) u_chk (
  .clk(clk), .rstN(rstN), .chipEn(chipEn), .busOe(busOe), .protoErr(protoErr),
  .ctrlBus(ctrlBus), .addrLo(addrLo), .addrHi(addrHi)
);

// File: tb/muxbus_ram_tb.sv
module muxbus_ram_tb;
  localparam int HI_W  = 3;
  localparam int DEPTH = 1 << (8 + HI_W);

  logic clk = 0, rstN = 0;
  logic [7:0] busIn = 0;
  logic [7:0] busOut;
  logic busOe, protoErr;
  logic strobeLo = 0, strobeHi = 0, chipEn = 0, rdEn = 0, wrEn = 0;

  int checks = 0, errors = 0;
  logic [7:0] refMem [DEPTH];
  logic       refVal [DEPTH];
  logic [7:0] curLo = 0;
  logic [HI_W-1:0] curHi = 0;

  always #2 clk = ~clk;

  muxbus_ram #(.HI_W(HI_W)) u_dut (
    .clk(clk), .rstN(rstN), .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .strobeLo(strobeLo), .strobeHi(strobeHi), .chipEn(chipEn), .rdEn(rdEn),
    .wrEn(wrEn), .protoErr(protoErr)
  );

  function automatic int curAddr(logic [HI_W-1:0] h, logic [7:0] l);
    return int'({h, l});
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setLo(input logic [7:0] v);
    busIn = v; waitCyc(1);
    strobeLo = 1; waitCyc(5); strobeLo = 0; waitCyc(3);
    curLo = v;
  endtask

  task automatic setHi(input logic [7:0] v);
    busIn = v; waitCyc(1);
    strobeHi = 1; waitCyc(5); strobeHi = 0; waitCyc(3);
    curHi = v[HI_W-1:0];
  endtask

  task automatic writeByte(input logic [7:0] d);
    busIn = d; waitCyc(1);
    wrEn = 1; waitCyc(5); wrEn = 0; waitCyc(3);
    if (chipEn) begin
      refMem[curAddr(curHi, curLo)] = d;
      refVal[curAddr(curHi, curLo)] = 1;
    end
  endtask

  task automatic readCheck(input string tag);
    int a;
    a = curAddr(curHi, curLo);
    rdEn = 1; waitCyc(5);
    chk(busOe === 1'b1, {tag, " R7 oe"}, busOe, 1);
    if (refVal[a]) chk(busOut === refMem[a], {tag, " R7 data"}, busOut, refMem[a]);
    rdEn = 0; waitCyc(4);
    chk(busOe === 1'b0, {tag, " R10 oe drop"}, busOe, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R10 actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < DEPTH; i++) refVal[i] = 0;
    waitCyc(3); rstN = 1; waitCyc(2);
    chk(busOe === 0, "R1 oe", busOe, 0);
    chk(protoErr === 0, "R1 err", protoErr, 0);
    chipEn = 1;
    // R1: address registers start at 0
    writeByte(8'h3c);
    setLo(8'h00); setHi(8'h00); readCheck("R1 addr0");

    // R2 R4: high first, then low
    setHi(8'h02); setLo(8'h05); writeByte(8'ha1);
    setLo(8'h06); writeByte(8'hb2);
    // R5: reuse high half, reload only the low half
    setLo(8'h05); readCheck("R5 reuse hi");
    // R4: low first, then high
    setLo(8'h06); setHi(8'h00); setHi(8'h02); readCheck("R4 order");
    // R3: upper bus lines ignored (0xE2 gives high = 2)
    setHi(8'h00); setLo(8'h05); setHi(8'he2); readCheck("R3 mask");

    // R6: one store per assertion, bus changes while wrEn held
    setLo(8'h07); busIn = 8'h11; waitCyc(1); wrEn = 1; waitCyc(5);
    busIn = 8'h99; waitCyc(6); wrEn = 0; waitCyc(3);
    refMem[curAddr(curHi, curLo)] = 8'h11; refVal[curAddr(curHi, curLo)] = 1;
    readCheck("R6 edge");

    // R8: chipEn low blocks write and read, strobes still load
    chipEn = 0; waitCyc(4);
    writeByte(8'h55);
    rdEn = 1; waitCyc(5);
    chk(busOe === 0, "R8 read ignored", busOe, 0);
    rdEn = 0;
    setLo(8'h05);
    chipEn = 1; waitCyc(4);
    readCheck("R8 no store and strobe works");
    chk(busOut === 8'ha1, "R8 lo loaded", busOut, 8'ha1);

    // random traffic
    for (int i = 0; i < 300; i++) begin
      int op;
      op = $urandom_range(0, 3);
      v = 8'($urandom);
      case (op)
        0: setLo(8'($urandom_range(0, 7)));
        1: setHi(v);
        2: writeByte(v);
        default: readCheck("R7 random");
      endcase
    end
    chk(protoErr === 0, "R9 err clear", protoErr, 0);

    // R9: conflict
    setLo(8'h03); writeByte(8'h77);
    busIn = 8'hee; waitCyc(1);
    rdEn = 1; wrEn = 1; waitCyc(6);
    chk(busOe === 0, "R9 oe low", busOe, 0);
    chk(protoErr === 1, "R9 err set", protoErr, 1);
    rdEn = 0; wrEn = 0; waitCyc(4);
    readCheck("R9 no store");
    chk(protoErr === 1, "R9 err sticky", protoErr, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule